// File: doc/BRIEF.md
# Frame Priority Classifier

This block sorts every received frame into one of two classes, high or low, for the two output queues of a switch port. It judges each frame on three criteria, and each criterion can be switched on or off on its own. The first is the ingress port number, compared against a port group picked by a 2-bit code. The second is the 802.1p priority code point of a VLAN tag. The third is the DiffServ code point of an IPv4 header. A frame is high priority when any enabled criterion marks it high. If a frame has no tag, or no IPv4 header, only the criteria that apply to it are used.

The block also marks frames sent to the reserved bridge group addresses 01-80-C2-00-00-03 up to 01-80-C2-00-00-0F, so the forwarding logic can drop them. When this option is off, such frames get no mark and are flooded as usual. Frame parsing happens upstream. The block receives the parsed fields alongside a valid strobe and returns its verdict on the next clock cycle.

The configuration comes from strap inputs. The block copies them on the first clock edge after reset is released and holds that copy until the next reset.

Top module: `prio_classifier`

## Requirements
- R1: After reset, `cls_valid_o`, `cls_high_o` and `cls_drop_o` are 0. A frame presented with `frm_valid_i`=1 at clock edge k gives `cls_valid_o`=1 after edge k and until edge k+1. When `cls_valid_o` is 0, the other two outputs are also 0.
- R2: The port group code works as follows. 00 means no port is high. 01 makes ports 0–1 high. 10 makes ports 0–3 high. 11 makes ports 0–7 high. Every other port is low under this criterion.
- R3: When the PCP criterion is enabled and `frm_tagged_i`=1, PCP values 4 to 7 mark the frame high and values 0 to 3 do not. An untagged frame is never marked by this criterion.
- R4: When the DSCP criterion is enabled and `frm_ipv4_i`=1, DSCP 46 (101110) and DSCP 10, 18, 26 and 34 (001010, 010010, 011010, 100010) mark the frame high. A frame without IPv4 is never marked by this criterion.
- R5: DSCP values matching 11x000 (48 and 56) mark the frame high when the DSCP criterion applies. Every DSCP value not named in R4 or R5 is low.
- R6: `cls_high_o` is the logical OR of the enabled criteria. A disabled criterion has no effect on the result.
- R7: When the drop strap is set, `cls_drop_o`=1 for a destination whose upper five octets are 01-80-C2-00-00 and whose last octet is 03 to 0F. The first octet is carried on `frm_dmac_i[47:40]`. The last octets 00 to 02, any value from 10 upward, and any other prefix give 0. When the drop strap is clear, `cls_drop_o` is always 0.
- R8: The straps are captured on the first clock edge after reset is released. Changes to the straps after that edge have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_port_mode_i | input | 2 | Port group code (R2) |
| strap_pcp_en_i | input | 1 | Enable the PCP criterion |
| strap_dscp_en_i | input | 1 | Enable the DSCP criterion |
| strap_drop_en_i | input | 1 | Enable marking of reserved group addresses |
| frm_valid_i | input | 1 | Parsed frame fields are valid |
| frm_port_i | input | PORT_W | Ingress port index |
| frm_tagged_i | input | 1 | Frame carries a VLAN tag |
| frm_pcp_i | input | 3 | Priority code point of the tag |
| frm_ipv4_i | input | 1 | Frame carries an IPv4 header |
| frm_dscp_i | input | 6 | DiffServ code point |
| frm_dmac_i | input | 48 | Destination MAC address, first octet in [47:40] |
| cls_valid_o | output | 1 | Verdict valid |
| cls_high_o | output | 1 | Frame is high priority |
| cls_drop_o | output | 1 | Frame is sent to a reserved group address and is to be dropped |

## Verification
The priority verdict and the drop mark are computed for the same frame and come out on the same cycle. A reserved-address frame can therefore be both high priority and marked for drop. The bench provokes this case by sending reserved-address frames whose port, PCP and DSCP are chosen to set each criterion, under every strap combination. Both outputs are judged against their separate expectations in that one sample. The bench also runs frames back to back, so that each verdict is checked to belong to the frame presented on the edge before it.

// File: rtl/prio_cls_pkg.sv
package prio_cls_pkg;
  localparam int DSCP_W    = 6;
  localparam int PCP_W     = 3;
  localparam int MAC_W     = 48;
  localparam int N_DSCP    = 6;
  localparam logic [PCP_W-1:0] PCP_HIGH_MIN = 3'd4;

  typedef struct packed {
    logic [1:0] port_mode;
    logic       pcp_en;
    logic       dscp_en;
    logic       drop_en;
  } cls_cfg_t;

  // value / care-mask pairs for high-priority code points
  typedef struct packed {
    logic [DSCP_W-1:0] val;
    logic [DSCP_W-1:0] care;
  } dscp_pat_t;

  localparam dscp_pat_t DSCP_PATS [N_DSCP] = '{
    '{val: 6'b101110, care: 6'b111111},
    '{val: 6'b001010, care: 6'b111111},
    '{val: 6'b010010, care: 6'b111111},
    '{val: 6'b011010, care: 6'b111111},
    '{val: 6'b100010, care: 6'b111111},
    '{val: 6'b110000, care: 6'b110111}
  };

  localparam logic [39:0] RSVD_PREFIX = 40'h01_80_C2_00_00;
  localparam logic [7:0]  RSVD_LO     = 8'h03;
  localparam logic [7:0]  RSVD_HI     = 8'h0F;
endpackage

// File: rtl/port_prio_map.sv
module port_prio_map #(
  parameter int PORT_W = 4
) (
  input  logic [1:0]        mode_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              hit_o
);
  localparam int N_PORT = 1 << PORT_W;

  logic [N_PORT-1:0] grp_mask;

  // mode m (m>0) selects ports below 2**m
  for (genvar p = 0; p < N_PORT; p++) begin : g_mask
    assign grp_mask[p] = (mode_i != 2'd0) && (p < (1 << mode_i));
  end

  assign hit_o = grp_mask[port_i];

  always_comb begin
    if (mode_i == 2'd0) p_mode_off_r2: assert (!hit_o);
    if (port_i >= PORT_W'(8)) p_far_port_low_r2: assert (!hit_o);
  end
endmodule

// File: rtl/pcp_prio_map.sv
module pcp_prio_map
  import prio_cls_pkg::*;
(
  input  logic             en_i,
  input  logic             tagged_i,
  input  logic [PCP_W-1:0] pcp_i,
  output logic             hit_o
);
  assign hit_o = en_i && tagged_i && (pcp_i >= PCP_HIGH_MIN);

  always_comb begin
    if (!tagged_i) p_untagged_low_r3: assert (!hit_o);
    if (!en_i)     p_pcp_off_r6: assert (!hit_o);
  end
endmodule

// File: rtl/dscp_prio_map.sv
module dscp_prio_map
  import prio_cls_pkg::*;
(
  input  logic              en_i,
  input  logic              ipv4_i,
  input  logic [DSCP_W-1:0] dscp_i,
  output logic              hit_o
);
  logic [N_DSCP-1:0] match;

  for (genvar i = 0; i < N_DSCP; i++) begin : g_pat
    assign match[i] = ((dscp_i ^ DSCP_PATS[i].val) & DSCP_PATS[i].care) == '0;
  end

  assign hit_o = en_i && ipv4_i && (|match);

  always_comb begin
    if (!ipv4_i) p_no_ipv4_low_r4: assert (!hit_o);
    if (en_i && ipv4_i && dscp_i == 6'b111000) p_dont_care_bit_r5: assert (hit_o);
    p_one_pattern_r5: assert ($onehot0(match));
  end
endmodule

// File: rtl/rsvd_addr_detect.sv
module rsvd_addr_detect
  import prio_cls_pkg::*;
(
  input  logic             en_i,
  input  logic [MAC_W-1:0] dmac_i,
  output logic             hit_o
);
  logic pfx_ok;
  logic [7:0] last;

  assign last   = dmac_i[7:0];
  assign pfx_ok = dmac_i[MAC_W-1:8] == RSVD_PREFIX;
  assign hit_o  = en_i && pfx_ok && (last >= RSVD_LO) && (last <= RSVD_HI);

  always_comb begin
    if (last < RSVD_LO) p_low_codes_kept_r7: assert (!hit_o);
    if (!en_i)          p_drop_off_r7: assert (!hit_o);
  end
endmodule

// File: rtl/prio_classifier.sv
module prio_classifier
  import prio_cls_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        strap_port_mode_i,
  input  logic              strap_pcp_en_i,
  input  logic              strap_dscp_en_i,
  input  logic              strap_drop_en_i,
  input  logic              frm_valid_i,
  input  logic [PORT_W-1:0] frm_port_i,
  input  logic              frm_tagged_i,
  input  logic [PCP_W-1:0]  frm_pcp_i,
  input  logic              frm_ipv4_i,
  input  logic [DSCP_W-1:0] frm_dscp_i,
  input  logic [MAC_W-1:0]  frm_dmac_i,
  output logic              cls_valid_o,
  output logic              cls_high_o,
  output logic              cls_drop_o
);
  cls_cfg_t cfg_q, cfg_now, cfg_eff;
  logic     cfg_done_q;

  assign cfg_now = '{port_mode: strap_port_mode_i, pcp_en: strap_pcp_en_i,
                     dscp_en: strap_dscp_en_i, drop_en: strap_drop_en_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      cfg_done_q <= 1'b0;
    end else if (!cfg_done_q) begin
      cfg_q      <= cfg_now;
      cfg_done_q <= 1'b1;
    end
  end

  // first cycle after reset uses straps directly
  assign cfg_eff = cfg_done_q ? cfg_q : cfg_now;

  logic port_hit, pcp_hit, dscp_hit, drop_hit;

  port_prio_map #(.PORT_W(PORT_W)) u_port (
    .mode_i (cfg_eff.port_mode),
    .port_i (frm_port_i),
    .hit_o  (port_hit)
  );

  pcp_prio_map u_pcp (
    .en_i     (cfg_eff.pcp_en),
    .tagged_i (frm_tagged_i),
    .pcp_i    (frm_pcp_i),
    .hit_o    (pcp_hit)
  );

  dscp_prio_map u_dscp (
    .en_i   (cfg_eff.dscp_en),
    .ipv4_i (frm_ipv4_i),
    .dscp_i (frm_dscp_i),
    .hit_o  (dscp_hit)
  );

  rsvd_addr_detect u_rsvd (
    .en_i   (cfg_eff.drop_en),
    .dmac_i (frm_dmac_i),
    .hit_o  (drop_hit)
  );

  logic valid_q, high_q, drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      high_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      valid_q <= frm_valid_i;
      high_q  <= frm_valid_i && (port_hit || pcp_hit || dscp_hit);
      drop_q  <= frm_valid_i && drop_hit;
    end
  end

  assign cls_valid_o = valid_q;
  assign cls_high_o  = high_q;
  assign cls_drop_o  = drop_q;

  p_valid_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> cls_valid_o);
  p_idle_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> !cls_valid_o);
  p_quiet_when_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cls_valid_o |-> !cls_high_o && !cls_drop_o);
  p_pcp_or_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && pcp_hit |=> cls_high_o);
  p_dscp_or_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && dscp_hit |=> cls_high_o);
  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_q |=> $stable(cfg_q) && cfg_done_q);
endmodule

// File: tb/prio_classifier_tb_top.sv
module prio_classifier_tb_top;
  localparam int PORT_W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] strap_port_mode_i = '0;
  logic strap_pcp_en_i = 0, strap_dscp_en_i = 0, strap_drop_en_i = 0;
  logic frm_valid_i = 0, frm_tagged_i = 0, frm_ipv4_i = 0;
  logic [PORT_W-1:0] frm_port_i = '0;
  logic [2:0] frm_pcp_i = '0;
  logic [5:0] frm_dscp_i = '0;
  logic [47:0] frm_dmac_i = '0;
  logic cls_valid_o, cls_high_o, cls_drop_o;

  int n_chk = 0, n_bad = 0;
  logic [1:0] c_mode;
  logic c_pcp, c_dscp, c_drop;

  always #5 clk_i = ~clk_i;

  prio_classifier #(.PORT_W(PORT_W)) dut_i (.*);

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  function automatic logic exp_high(input int port, input logic tg, input int pcp,
                                    input logic v4, input int dscp);
    logic h = 0;
    if (c_mode != 0 && port < (1 << c_mode)) h = 1;
    if (c_pcp && tg && pcp >= 4) h = 1;
    if (c_dscp && v4 && (dscp == 46 || dscp == 10 || dscp == 18 || dscp == 26 ||
                         dscp == 34 || dscp == 48 || dscp == 56)) h = 1;
    return h;
  endfunction

  function automatic logic exp_drop(input logic [47:0] mac);
    return c_drop && mac[47:8] == 40'h0180C20000 && mac[7:0] >= 3 && mac[7:0] <= 15;
  endfunction

  // present a frame for one cycle, check its verdict one cycle later
  task automatic send(input int port, input logic tg, input int pcp, input logic v4,
                      input int dscp, input logic [47:0] mac, input string req);
    @(negedge clk_i);
    frm_valid_i = 1; frm_port_i = PORT_W'(port); frm_tagged_i = tg;
    frm_pcp_i = 3'(pcp); frm_ipv4_i = v4; frm_dscp_i = 6'(dscp); frm_dmac_i = mac;
    @(negedge clk_i);
    frm_valid_i = 0;
    check({req, " valid R1"}, cls_valid_o, 1'b1);
    check({req, " high"}, cls_high_o, exp_high(port, tg, pcp, v4, dscp));
    check({req, " drop R7"}, cls_drop_o, exp_drop(mac));
  endtask

  task automatic do_reset(input logic [1:0] m, input logic p, input logic d, input logic dr);
    @(negedge clk_i);
    rst_ni = 0;
    strap_port_mode_i = m; strap_pcp_en_i = p; strap_dscp_en_i = d; strap_drop_en_i = dr;
    c_mode = m; c_pcp = p; c_dscp = d; c_drop = dr;
    @(negedge clk_i);
    check("reset valid R1", cls_valid_o, 1'b0);
    check("reset high R1", cls_high_o, 1'b0);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  initial begin
    fork
      begin
        for (int cfg = 0; cfg < 32; cfg++) begin
          do_reset(cfg[1:0], cfg[2], cfg[3], cfg[4]);
          for (int p = 0; p < 16; p++) send(p, 0, 0, 0, 0, 48'h0, "port map R2");
          for (int t = 0; t < 2; t++)
            for (int q = 0; q < 8; q++) send(15, t[0], q, 0, 0, 48'h0, "pcp R3");
          for (int v = 0; v < 2; v++)
            for (int s = 0; s < 64; s++) send(15, 0, 0, v[0], s, 48'h0, "dscp R4 R5");
          for (int b = 0; b < 20; b++)
            send(15, 0, 0, 0, 0, {40'h0180C20000, 8'(b)}, "rsvd R7");
          send(15, 0, 0, 0, 0, 48'h0180C2000105, "rsvd prefix R7");
          send(15, 0, 0, 0, 0, 48'h0180C20000FF, "rsvd top R7");
          // combined criteria plus drop in one verdict
          for (int k = 0; k < 32; k++)
            send(k % 16, k[0], (k * 3) % 8, k[1], (k * 7) % 64,
                 {40'h0180C20000, 8'(k % 18)}, "combine R6");
          // idle cycle gives quiet outputs
          @(negedge clk_i);
          check("idle valid R1", cls_valid_o, 1'b0);
          check("idle high R1", cls_high_o, 1'b0);
          check("idle drop R1", cls_drop_o, 1'b0);
        end
        // back-to-back frames
        do_reset(2'b01, 0, 1, 0);
        @(negedge clk_i);
        frm_valid_i = 1; frm_port_i = 0; frm_ipv4_i = 0;
        @(negedge clk_i);
        check("b2b first R1", cls_high_o, 1'b1);
        frm_port_i = 9; frm_ipv4_i = 1; frm_dscp_i = 6'd0;
        @(negedge clk_i);
        check("b2b second R1", cls_high_o, 1'b0);
        check("b2b valid R1", cls_valid_o, 1'b1);
        frm_valid_i = 0;
        // strap changes after capture are ignored
        do_reset(2'b00, 0, 0, 0);
        strap_port_mode_i = 2'b11; strap_pcp_en_i = 1; strap_dscp_en_i = 1; strap_drop_en_i = 1;
        send(0, 1, 7, 1, 46, 48'h0180C2000005, "strap hold R8");
        // and are picked up by the next reset
        do_reset(2'b11, 1, 1, 1);
        send(0, 1, 7, 1, 46, 48'h0180C2000005, "strap reload R8");
      end
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1 act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule